// File: doc/BRIEF.md
# Mixed-Cell Boundary-Scan Data Register

This block is the boundary-scan data register of a device whose digital pads are tested over a JTAG port. It sits between TDI and TDO and is clocked by TCK. Each digital pad has one cell, and each cell is one of three kinds. An input cell holds one chain bit. An output cell holds two bits: an enable and a data value. A bidirectional cell holds three bits: an enable, a data value and a captured pad level. The cells are chained in a fixed pad order, and the default layout gives a chain of 62 bits over 30 pads.

The TAP controller supplies three strobes: capture, shift and update. On a capture edge each cell samples its live pad level or the core's current enable and data. On shift edges the chain moves one place toward TDO. On an update edge the shifted pattern is copied into the update stage. A mode select picks between two pad behaviours. In the external-test mode the update stage drives the pad enables and pad outputs. Otherwise the pads pass the core's enable and data straight through. The test pattern is loaded and read through the same capture, shift and update sequence that a sample/preload instruction uses.

Top module: `bscan_chain`

## Requirements
- R1: With the default layout the chain between TDI and TDO is 62 bits long. A bit shifted in at TDI first appears at TDO after exactly 62 shift edges.
- R2: On each TCK rising edge with shift_dr high, every chain bit moves one place toward bit 0. TDI enters bit 61, and TDO always shows bit 0. The first bit shifted into a cell ends up at that cell's lowest bit.
- R3: On a capture_dr edge, an input cell's single bit loads pad_in of its pad.
- R4: On a capture_dr edge, an output cell's lower bit loads core_oe and its upper bit loads core_out.
- R5: On a capture_dr edge, a bidirectional cell's bits load, from low to high: core_oe, core_out and pad_in.
- R6: The update stage changes only on an update_dr edge. In the external-test mode, pad_oe and pad_out hold steady through capture and shift edges.
- R7: When extest is 1, each output or bidirectional pad takes pad_oe from its cell's lower updated bit (the first bit shifted in). It takes pad_out from the next updated bit.
- R8: When extest is 1, shifting 0-x-0 into a bidirectional cell and updating leaves the pad undriven (pad_oe 0). Shifting 1-x-1 drives it (pad_oe 1, pad_out equal to the middle bit).
- R9: When extest is 0, each output or bidirectional pad follows the core combinationally: pad_oe equals core_oe and pad_out equals core_out. The update stage's contents have no effect.
- R10: Input pads never drive. Their pad_oe and pad_out are 0 in both modes.
- R11: A low trst_n clears the shift stage and the update stage at once, without waiting for TCK. While it is low, TDO is 0 and, in the external-test mode, every pad_oe is 0.
- R12: Pad kinds are coded as 0 for input, 1 for output and 2 for bidirectional. Pad k uses LAYOUT bits [2k+1:2k]. Chain offsets are assigned from pad 0 upward. The default kinds for pads 0 to 29 are: B B I I O O O I B I B B B B B B B B I I O O O I I B B I I I.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data into the chain's top bit |
| tdo | output | 1 | Serial data out of chain bit 0 |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update strobe from the TAP controller |
| extest | input | 1 | 1 selects external-test pad control, 0 selects core pass-through |
| pad_in | input | NPADS | Live level of each pad |
| core_out | input | NPADS | Core data for each pad |
| core_oe | input | NPADS | Core output enable for each pad |
| pad_out | output | NPADS | Data driven toward each pad |
| pad_oe | output | NPADS | Driver enable for each pad |

## Verification
The assertions assume that the TAP controller raises at most one of capture_dr, shift_dr and update_dr in any cycle. They also treat capture as taking priority if that assumption is ever broken. The bench drives only one strobe per step task and clears all three before the next step, so this assumption always holds. The stability checks also assume that extest is changed only away from the clock edge. The bench meets this by driving every input, including extest and trst_n, at the falling edge.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        CK_IN    = 2'd0,
        CK_OUT   = 2'd1,
        CK_BIDIR = 2'd2
    } cell_kind_e;

    localparam int MAX_W = 3;

    typedef struct packed {
        logic [MAX_W-1:0] sr;
        logic [MAX_W-1:0] upd;
    } cell_state_t;

    // Pads 29 down to 0, two bits each
    localparam int DEF_PADS = 30;
    localparam logic [2*DEF_PADS-1:0] DEF_LAYOUT = {
        2'd0, 2'd0, 2'd0, 2'd2, 2'd2, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1,
        2'd0, 2'd0, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2,
        2'd0, 2'd2, 2'd0, 2'd1, 2'd1, 2'd1, 2'd0, 2'd0, 2'd2, 2'd2
    };

    function automatic int kind_width(cell_kind_e k);
        case (k)
            CK_OUT:   return 2;
            CK_BIDIR: return 3;
            default:  return 1;
        endcase
    endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
#(
    parameter cell_kind_e KIND = CK_IN
) (
    input  logic tck,
    input  logic trst_n,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic si,
    input  logic pad_in,
    input  logic core_out,
    input  logic core_oe,
    output logic so,
    output logic upd_oe,
    output logic upd_out
);

    localparam int W = kind_width(KIND);

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            case (KIND)
                CK_OUT:   st_d.sr = {1'b0, core_out, core_oe};
                CK_BIDIR: st_d.sr = {pad_in, core_out, core_oe};
                default:  st_d.sr = {2'b00, pad_in};
            endcase
        end else if (shift) begin
            case (W)
                1:       st_d.sr = {2'b00, si};
                2:       st_d.sr = {1'b0, si, st_q.sr[1]};
                default: st_d.sr = {si, st_q.sr[2:1]};
            endcase
        end else if (update) begin
            st_d.upd = st_q.sr;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign so = st_q.sr[0];

    generate
        if (KIND == CK_IN) begin : g_nodrive
            assign upd_oe  = 1'b0;
            assign upd_out = 1'b0;
        end else begin : g_drive
            assign upd_oe  = st_q.upd[0];
            assign upd_out = st_q.upd[1];
        end
    endgenerate

    // Serial entry lands in the cell's top bit
    assert_shift_entry_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (shift && !capture) |=> (st_q.sr[W-1] == $past(si)));

    // Held pattern moves only on an update strobe
    assert_update_only_R6: assert property (@(posedge tck) disable iff (!trst_n)
        !update |=> $stable(st_q.upd));

    generate
        if (KIND == CK_IN) begin : g_cap_in
            assert_capture_in_R3: assert property (@(posedge tck) disable iff (!trst_n)
                capture |=> (st_q.sr[0] == $past(pad_in)));
        end else if (KIND == CK_OUT) begin : g_cap_out
            assert_capture_out_R4: assert property (@(posedge tck) disable iff (!trst_n)
                capture |=> (st_q.sr[1:0] == {$past(core_out), $past(core_oe)}));
        end else begin : g_cap_bidir
            assert_capture_bidir_R5: assert property (@(posedge tck) disable iff (!trst_n)
                capture |=> (st_q.sr == {$past(pad_in), $past(core_out), $past(core_oe)}));
        end
    endgenerate

endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux
    import bscan_pkg::*;
#(
    parameter cell_kind_e KIND = CK_IN
) (
    input  logic extest,
    input  logic core_out,
    input  logic core_oe,
    input  logic upd_oe,
    input  logic upd_out,
    output logic pad_out,
    output logic pad_oe
);

    always_comb begin
        if (KIND == CK_IN) begin
            pad_oe  = 1'b0;
            pad_out = 1'b0;
        end else if (extest) begin
            pad_oe  = upd_oe;
            pad_out = upd_out;
        end else begin
            pad_oe  = core_oe;
            pad_out = core_out;
        end
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int                      NPADS  = DEF_PADS,
    parameter logic [2*NPADS-1:0]      LAYOUT = DEF_LAYOUT
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    output logic             tdo,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             extest,
    input  logic [NPADS-1:0] pad_in,
    input  logic [NPADS-1:0] core_out,
    input  logic [NPADS-1:0] core_oe,
    output logic [NPADS-1:0] pad_out,
    output logic [NPADS-1:0] pad_oe
);

    // ser[k] leaves pad k's cell; ser[NPADS] is the entry from TDI
    logic [NPADS:0] ser;
    logic [NPADS-1:0] upd_oe, upd_out;

    assign ser[NPADS] = tdi;
    assign tdo        = ser[0];

    generate
        for (genvar k = 0; k < NPADS; k++) begin : g_pad
            localparam cell_kind_e KK = cell_kind_e'(LAYOUT[2*k +: 2]);

            bscan_cell #(.KIND(KK)) u_cell (
                .tck      (tck),
                .trst_n   (trst_n),
                .capture  (capture_dr),
                .shift    (shift_dr),
                .update   (update_dr),
                .si       (ser[k+1]),
                .pad_in   (pad_in[k]),
                .core_out (core_out[k]),
                .core_oe  (core_oe[k]),
                .so       (ser[k]),
                .upd_oe   (upd_oe[k]),
                .upd_out  (upd_out[k])
            );

            bscan_pad_mux #(.KIND(KK)) u_mux (
                .extest   (extest),
                .core_out (core_out[k]),
                .core_oe  (core_oe[k]),
                .upd_oe   (upd_oe[k]),
                .upd_out  (upd_out[k]),
                .pad_out  (pad_out[k]),
                .pad_oe   (pad_oe[k])
            );

            if (KK != CK_IN) begin : g_chk
                assert_passthrough_R9: assert property (@(posedge tck) disable iff (!trst_n)
                    !extest |-> (pad_oe[k] == core_oe[k] && pad_out[k] == core_out[k]));
            end
        end
    endgenerate

    // TAP raises at most one data-register strobe per cycle
    assert_strobe_exclusive_R2: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({capture_dr, shift_dr, update_dr}));

    // Pads stay put in external test unless an update occurs
    assert_pad_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (extest && !update_dr) |=> (!extest || ($stable(pad_oe) && $stable(pad_out))));

endmodule

// File: tb/sim_bscan_chain.sv
module sim_bscan_chain;

    localparam int TCK_PERIOD = 10;
    localparam int NP = 30;
    localparam int CL = 62;

    // Pad kinds 29..0 (0 input, 1 output, 2 bidirectional)
    localparam logic [2*NP-1:0] KINDS = {
        2'd0, 2'd0, 2'd0, 2'd2, 2'd2, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1,
        2'd0, 2'd0, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2,
        2'd0, 2'd2, 2'd0, 2'd1, 2'd1, 2'd1, 2'd0, 2'd0, 2'd2, 2'd2
    };

    // {shift pattern, pad_in, core_out, core_oe}
    localparam logic [CL+3*NP-1:0] VEC [4] = '{
        {62'h0,                  30'h3FFFFFFF, 30'h0,        30'h0},
        {62'h3FFF_FFFF_FFFF_FFFF, 30'h0,        30'h3FFFFFFF, 30'h3FFFFFFF},
        {62'h2AAA_AAAA_AAAA_AAAA, 30'h15555555, 30'h2AAAAAAA, 30'h15555555},
        {62'h1234_5678_9ABC_DEF0, 30'h0F0F0F0F, 30'h3C3C3C3C, 30'h23456789}
    };

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tdi = 1'b0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, extest = 1'b0;
    logic [NP-1:0] pad_in = '0, core_out = '0, core_oe = '0;
    logic tdo;
    logic [NP-1:0] pad_out, pad_oe;

    int checks = 0;
    int fails  = 0;

    always #(TCK_PERIOD/2) tck = ~tck;

    bscan_chain u0 (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .extest(extest), .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic int kind_of(int k);
        return int'(KINDS[2*k +: 2]);
    endfunction

    function automatic int width_of(int k);
        return (kind_of(k) == 2) ? 3 : (kind_of(k) == 1) ? 2 : 1;
    endfunction

    function automatic int off_of(int k);
        int o = 0;
        for (int j = 0; j < k; j++) o += width_of(j);
        return o;
    endfunction

    function automatic logic [NP-1:0] drv_mask();
        logic [NP-1:0] m = '0;
        for (int k = 0; k < NP; k++) m[k] = (kind_of(k) != 0);
        return m;
    endfunction

    function automatic logic [CL-1:0] exp_capture(logic [NP-1:0] pin, cout, coe);
        logic [CL-1:0] c = '0;
        for (int k = 0; k < NP; k++) begin
            int o = off_of(k);
            if (kind_of(k) == 0) c[o] = pin[k];
            else begin
                c[o] = coe[k];
                c[o+1] = cout[k];
                if (kind_of(k) == 2) c[o+2] = pin[k];
            end
        end
        return c;
    endfunction

    function automatic logic [NP-1:0] exp_oe(logic [CL-1:0] p);
        logic [NP-1:0] r = '0;
        for (int k = 0; k < NP; k++) if (kind_of(k) != 0) r[k] = p[off_of(k)];
        return r;
    endfunction

    function automatic logic [NP-1:0] exp_out(logic [CL-1:0] p);
        logic [NP-1:0] r = '0;
        for (int k = 0; k < NP; k++) if (kind_of(k) != 0) r[k] = p[off_of(k)+1];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic s, input logic u, input logic d);
        capture_dr = c; shift_dr = s; update_dr = u; tdi = d;
        @(posedge tck);
        @(negedge tck);
        capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0; tdi = 1'b0;
    endtask

    task automatic shift_chain(input logic [CL-1:0] pat, output logic [CL-1:0] got);
        for (int i = 0; i < CL; i++) begin
            got[i] = tdo;
            step(1'b0, 1'b1, 1'b0, pat[i]);
        end
    endtask

    initial begin
        #(TCK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [CL-1:0] got;
        logic [CL-1:0] pat;
        logic [NP-1:0] prev_oe, prev_out;

        // R11: reset state
        core_oe = '1; core_out = '1;
        repeat (3) @(negedge tck);
        #1;
        chk("R11 tdo in reset", 64'(tdo), 64'(0));
        chk("R11 passthrough oe in reset", 64'(pad_oe), 64'(drv_mask()));
        extest = 1'b1;
        #1;
        chk("R11 extest oe cleared", 64'(pad_oe), 64'(0));
        chk("R11 extest out cleared", 64'(pad_out), 64'(0));
        @(negedge tck);
        trst_n = 1'b1;
        @(negedge tck);

        // Vector walk: capture, shift out/in, update
        prev_oe = '0; prev_out = '0;
        for (int v = 0; v < 4; v++) begin
            pat      = VEC[v][CL+3*NP-1 -: CL];
            pad_in   = VEC[v][3*NP-1 -: NP];
            core_out = VEC[v][2*NP-1 -: NP];
            core_oe  = VEC[v][NP-1:0];
            step(1'b1, 1'b0, 1'b0, 1'b0);
            chk("R6 oe steady after capture", 64'(pad_oe), 64'(prev_oe));
            shift_chain(pat, got);
            chk("R3 R4 R5 R12 captured chain", 64'(got), 64'(exp_capture(pad_in, core_out, core_oe)));
            chk("R6 oe steady after shift", 64'(pad_oe), 64'(prev_oe));
            chk("R6 out steady after shift", 64'(pad_out), 64'(prev_out));
            step(1'b0, 1'b0, 1'b1, 1'b0);
            chk("R7 R10 oe after update", 64'(pad_oe), 64'(exp_oe(pat)));
            chk("R7 R10 out after update", 64'(pad_out), 64'(exp_out(pat)));
            prev_oe = exp_oe(pat); prev_out = exp_out(pat);
        end

        // R1: chain length
        shift_chain('0, got);
        step(1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < CL-2; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R1 tdo after 61 shifts", 64'(tdo), 64'(0));
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R1 tdo after 62 shifts", 64'(tdo), 64'(1));
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R2 tdo after 63 shifts", 64'(tdo), 64'(0));

        // R8: pad 0 gets 0-1-0, pad 1 gets 1-0-1
        pat = '0;
        pat[5:0] = 6'b101010;
        shift_chain(pat, got);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 bidir 0x0 undriven", 64'(pad_oe[0]), 64'(0));
        chk("R8 bidir 1x1 driven", 64'(pad_oe[1]), 64'(1));
        chk("R8 bidir 1x1 data", 64'(pad_out[1]), 64'(0));

        // R9 and R10: pass-through ignores the loaded pattern
        pat = '1;
        shift_chain(pat, got);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        extest = 1'b0;
        core_oe = 30'h0AAAAAAA; core_out = 30'h15555555;
        #1;
        chk("R9 passthrough oe", 64'(pad_oe), 64'(core_oe & drv_mask()));
        chk("R9 passthrough out", 64'(pad_out), 64'(core_out & drv_mask()));
        core_oe = '1; core_out = '1;
        #1;
        chk("R10 input pads oe zero", 64'(pad_oe & ~drv_mask()), 64'(0));
        chk("R10 input pads out zero", 64'(pad_out & ~drv_mask()), 64'(0));
        extest = 1'b1;
        #1;
        chk("R7 latches reapplied", 64'(pad_oe), 64'(drv_mask()));

        // R11: asynchronous reset mid-test
        @(negedge tck);
        #2;
        trst_n = 1'b0;
        #1;
        chk("R11 async oe clear", 64'(pad_oe), 64'(0));
        chk("R11 async tdo clear", 64'(tdo), 64'(0));
        @(negedge tck);
        trst_n = 1'b1;
        @(negedge tck);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule